// File: doc/BRIEF.md
# Low-Power System Clock Controller

This block derives the CPU clock enable and the peripheral tick enables of a small microcontroller from two oscillator tick inputs: a fast main clock and a slow sub-clock. Each oscillator is modelled as a one-cycle enable pulse on the system clock `clk`. A byte-wide control register chooses the CPU clock source and the main-clock divisor. It also starts the sub-oscillator, stops the main oscillator, holds the drive-strength settings and decides whether a WAIT instruction freezes the peripheral ticks.

With the main clock as source, the CPU enable fires once every 1, 2, 4, 8 or 16 main ticks. With the sub-clock as source, it follows the sub tick undivided. A new divisor is adopted only at the end of the running CPU period. The peripheral enables are the main tick divided by 1, 8 and 32. The timer tick is the sub tick divided by 32. The watchdog tick is the undivided sub tick. Several writes are refused so that the CPU clock can never stop. Entry to stop mode raises the drive-strength bits, and the main-clock side of them only when the CPU is running from the main clock.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the control register reads 0x4A, so the CPU enable is the main tick divided by 8 and `fc_en` stays low whatever `sub_tick` does. The register bits are: 1 main drive, 2 WAIT peripheral stop, 3 sub drive, 4 sub-oscillator enable, 5 main stop, 6 divider bit 0, 7 source select.
- R2: With bit 7 at 0, bit 6 at 1 gives one `cpu_en` per 8 main ticks. With bit 6 at 0, `div_hi` values 00, 01, 10 and 11 give one `cpu_en` per 1, 2, 4 and 16 main ticks.
- R3: A divisor change takes effect only after the CPU period that is running completes with the old divisor.
- R4: A write setting bit 7 is accepted only if bit 4 already reads 1 and `sub_stable` is high. Otherwise bit 7 stays 0. While bit 7 is 1, `cpu_en` equals `fc_en`.
- R5: A write setting bit 5 is accepted only if bit 7 already reads 1. While bit 5 ends up 1, bit 7 is kept at 1. While bit 7 is 1, bit 4 is kept at 1.
- R6: `f1_en`, `f8_en` and `f32_en` fire on every main tick, on every 8th main tick and on every 32nd main tick, counted from reset. All three stay low while bit 5 is 1, and so does the main-derived `cpu_en`.
- R7: A `wait_req` pulse while bit 2 is 1 silences the three peripheral enables from the next cycle on. They stay silent through the cycle in which `irq` is high and resume on the next main tick. With bit 2 at 0, `wait_req` has no effect on them.
- R8: `fc_en` follows `sub_tick` while bit 4 is 1. `fc32_en` fires on every 32nd `fc_en`.
- R9: A `stop_req` pulse sets bit 3. It also sets bits 1 and 6 if bit 7 is 0, and leaves them unchanged if bit 7 is 1.
- R10: Bit 0 always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| sub_tick | input | 1 | One-cycle pulse per sub oscillator period |
| sub_stable | input | 1 | Sub-oscillator has settled |
| div_hi | input | 2 | Divisor choice used when register bit 6 is 0 |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| wait_req | input | 1 | Pulse: WAIT instruction executes |
| irq | input | 1 | Interrupt request, ends the WAIT state |
| stop_req | input | 1 | Pulse: entry to stop mode |
| cpu_en | output | 1 | CPU clock enable |
| f1_en | output | 1 | Peripheral tick, main / 1 |
| f8_en | output | 1 | Peripheral tick, main / 8 |
| f32_en | output | 1 | Peripheral tick, main / 32 |
| fc_en | output | 1 | Sub-clock tick for the watchdog |
| fc32_en | output | 1 | Sub-clock / 32 tick for the timers |

## Verification
The bench moves the divisor in the middle of a CPU period. A design that switches at once would produce a shortened period and too many pulses in the counted window. It writes the source-select and main-stop bits in the forbidden orders, without a stable sub-oscillator, and tries to drop the select while the main clock is stopped. A missing guard there shows up as a changed register value or a dead CPU enable. It enters stop mode from both sources and checks which drive and divider bits were forced. It also times the WAIT release against the interrupt cycle, so a gate that reopens one tick early or one tick late changes the peripheral pulse count.

// File: rtl/sysclk_pkg.sv
// Shared constants for the system clock controller: control register bit
// positions, reset value and the divisor decode. Assumes an 8-bit register.
package sysclk_pkg;

    localparam int CTRL_W  = 8;
    localparam int DIV_W   = 5;          // wide enough to hold a ratio of 16

    localparam int B_MDRV  = 1;          // main oscillator drive strength
    localparam int B_WSTOP = 2;          // stop peripheral ticks in WAIT
    localparam int B_SDRV  = 3;          // sub oscillator drive strength
    localparam int B_SUBEN = 4;          // sub oscillator enable
    localparam int B_MSTOP = 5;          // main oscillator stop
    localparam int B_DIV0  = 6;          // divider select bit 0
    localparam int B_SEL   = 7;          // CPU source: 1 = sub-clock

    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h4A;

    // Main-clock divide ratio from divider bit 0 and the two upper select bits.
    function automatic logic [DIV_W-1:0] div_ratio(input logic d0, input logic [1:0] hi);
        logic [DIV_W-1:0] r;
        if (d0) begin
            r = DIV_W'(8);
        end else begin
            case (hi)
                2'd0:    r = DIV_W'(1);
                2'd1:    r = DIV_W'(2);
                2'd2:    r = DIV_W'(4);
                default: r = DIV_W'(16);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sysclk_ctrl_reg.sv
// Control register with write guards and stop-mode forcing.
// Assumes stop_req and reg_we are single-cycle pulses; stop_req wins if both occur.
module sysclk_ctrl_reg
    import sysclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              sub_stable,
    input  logic              stop_req,
    output logic [CTRL_W-1:0] ctrl
);

    logic [CTRL_W-1:0] nxt;
    logic              n_sel;
    logic              n_mstop;
    logic              wdata_unused;

    assign wdata_unused = wdata[0];

    // Next register value: stop forcing, else guarded write, else hold.
    always_comb begin
        nxt     = ctrl;
        n_mstop = wdata[B_MSTOP] & ctrl[B_SEL];
        if (wdata[B_SEL])
            n_sel = ctrl[B_SEL] | (ctrl[B_SUBEN] & sub_stable);
        else
            n_sel = n_mstop;
        if (stop_req) begin
            nxt[B_SDRV] = 1'b1;
            if (!ctrl[B_SEL]) begin
                nxt[B_MDRV] = 1'b1;
                nxt[B_DIV0] = 1'b1;
            end
        end else if (we) begin
            nxt[0]       = 1'b0;
            nxt[B_MDRV]  = wdata[B_MDRV];
            nxt[B_WSTOP] = wdata[B_WSTOP];
            nxt[B_SDRV]  = wdata[B_SDRV];
            nxt[B_SUBEN] = wdata[B_SUBEN] | n_sel;
            nxt[B_MSTOP] = n_mstop;
            nxt[B_DIV0]  = wdata[B_DIV0];
            nxt[B_SEL]   = n_sel;
        end
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= CTRL_RST;
        else        ctrl <= nxt;
    end

endmodule

// File: rtl/sysclk_main_div.sv
// Main-clock divider for the CPU enable. The active ratio is reloaded only at
// a period boundary so that no period is ever shortened. Assumes req >= 1.
module sysclk_main_div
    import sysclk_pkg::*;
#(
    parameter int CNT_W = DIV_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] req,
    output logic             pulse
);

    localparam logic [CNT_W-1:0] RST_RATIO = CNT_W'(8);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act;

    assign pulse = tick && (cnt == act - CNT_W'(1));

    // Count ticks; at the boundary restart and adopt the requested ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= RST_RATIO;
        end else if (pulse) begin
            cnt <= '0;
            act <= req;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sysclk_pow2_div.sv
// Power-of-two tick divider: passes every 2**LOG2-th input tick.
module sysclk_pow2_div #(
    parameter int LOG2 = 3
)(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic pulse
);

    logic [LOG2-1:0] cnt;

    assign pulse = tick && (&cnt);

    // Free-running count of input ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sysclk_ctrl.sv
// System clock controller top: source mux, main divider, peripheral and
// sub-clock tick dividers, WAIT gating. Oscillators arrive as tick enables.
module sysclk_ctrl
    import sysclk_pkg::*;
#(
    parameter int F8_LOG2   = 3,
    parameter int F32_LOG2  = 5,
    parameter int FC32_LOG2 = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_tick,
    input  logic              sub_tick,
    input  logic              sub_stable,
    input  logic [1:0]        div_hi,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              wait_req,
    input  logic              irq,
    input  logic              stop_req,
    output logic              cpu_en,
    output logic              f1_en,
    output logic              f8_en,
    output logic              f32_en,
    output logic              fc_en,
    output logic              fc32_en
);

    localparam int NPER = 2;

    logic [CTRL_W-1:0] ctrl;
    logic              main_g;
    logic              main_cpu;
    logic              wait_st;
    logic              per_on;
    logic [NPER-1:0]   per_pulse;

    sysclk_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .sub_stable (sub_stable),
        .stop_req   (stop_req),
        .ctrl       (ctrl)
    );

    assign reg_rdata = ctrl;
    assign main_g    = main_tick & ~ctrl[B_MSTOP];
    assign fc_en     = sub_tick & ctrl[B_SUBEN];

    sysclk_main_div #(.CNT_W(DIV_W)) u_cpu_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (main_g),
        .req   (div_ratio(ctrl[B_DIV0], div_hi)),
        .pulse (main_cpu)
    );

    assign cpu_en = ctrl[B_SEL] ? fc_en : main_cpu;

    // WAIT state: entered by a WAIT pulse, left on an interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n)        wait_st <= 1'b0;
        else if (irq)      wait_st <= 1'b0;
        else if (wait_req) wait_st <= 1'b1;
    end

    assign per_on = ~(wait_st & ctrl[B_WSTOP]);
    assign f1_en  = main_g & per_on;

    for (genvar g = 0; g < NPER; g++) begin : g_per
        localparam int L = (g == 0) ? F8_LOG2 : F32_LOG2;
        sysclk_pow2_div #(.LOG2(L)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (f1_en),
            .pulse (per_pulse[g])
        );
    end

    assign f8_en  = per_pulse[0];
    assign f32_en = per_pulse[1];

    sysclk_pow2_div #(.LOG2(FC32_LOG2)) u_fc32 (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (fc_en),
        .pulse (fc32_en)
    );

endmodule

// File: rtl/sysclk_ctrl_chk.sv
// Assertion checker for sysclk_ctrl, attached by bind. Observes ports only.
module sysclk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sub_stable,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       wait_req,
    input logic       irq,
    input logic       stop_req,
    input logic       cpu_en,
    input logic       f1_en,
    input logic       f8_en,
    input logic       fc_en,
    input logic       fc32_en
);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> reg_rdata == 8'h4A);

    a_r4_sel_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[7]) |-> ($past(sub_stable) && $past(reg_rdata[4])));

    a_r4_sub_source: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] |-> cpu_en == fc_en);

    a_r5_stop_needs_sub: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] |-> (reg_rdata[7] && reg_rdata[4]));

    a_r6_main_off: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] |-> !f1_en);

    a_r6_nested: assert property (@(posedge clk) disable iff (!rst_n)
        f8_en |-> f1_en);

    a_r7_wait_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && reg_rdata[2] && !irq && !reg_we && !stop_req) |=> !f1_en);

    a_r8_fc32_nested: assert property (@(posedge clk) disable iff (!rst_n)
        fc32_en |-> fc_en);

    a_r9_stop_sub_drive: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> reg_rdata[3]);

    a_r9_stop_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !reg_rdata[7]) |=> (reg_rdata[6] && reg_rdata[1]));

    a_r9_stop_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && reg_rdata[7]) |=> (reg_rdata[6] == $past(reg_rdata[6])));

endmodule

bind sysclk_ctrl sysclk_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sub_stable (sub_stable),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .wait_req   (wait_req),
    .irq        (irq),
    .stop_req   (stop_req),
    .cpu_en     (cpu_en),
    .f1_en      (f1_en),
    .f8_en      (f8_en),
    .fc_en      (fc_en),
    .fc32_en    (fc32_en)
);

// File: tb/test_sysclk_ctrl.sv
// Scoreboard bench: the driver pushes expected values, the monitor compares
// them against the observed values as they arrive.
module test_sysclk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0, sub_tick = 1'b0, sub_stable = 1'b0;
    logic [1:0] div_hi = 2'b00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wait_req = 1'b0, irq = 1'b0, stop_req = 1'b0;
    logic       cpu_en, f1_en, f8_en, f32_en, fc_en, fc32_en;

    typedef struct { string tag; int val; } item_t;
    item_t exp_q[$];
    int    act_q[$];
    int    n_checks = 0, n_errors = 0;
    bit    done = 1'b0;
    int    c_cpu, c_f1, c_f8, c_f32, c_fc, c_fc32;

    always #5 clk = ~clk;

    sysclk_ctrl i_sysclk_ctrl (.*);

    // Monitor: pop expected/observed pairs and compare them.
    always @(posedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e;
            int a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_checks++;
            if (a != e.val) begin
                n_errors++;
                $display("FAIL %s: actual=%0d expected=%0d", e.tag, a, e.val);
            end
        end
    end

    task automatic push(input string tag, input int act, input int exp);
        exp_q.push_back('{tag, exp});
        act_q.push_back(act);
    endtask

    // One cycle: drive at the falling edge, sample outputs 2 ns later.
    task automatic step(input bit mt, input bit st, input bit we = 0, input logic [7:0] wd = 8'h00,
                        input bit wr = 0, input bit ir = 0, input bit sp = 0);
        @(negedge clk);
        main_tick = mt; sub_tick = st; reg_we = we; reg_wdata = wd;
        wait_req = wr; irq = ir; stop_req = sp;
        #2;
        c_cpu += int'(cpu_en); c_f1 += int'(f1_en); c_f8 += int'(f8_en);
        c_f32 += int'(f32_en); c_fc += int'(fc_en); c_fc32 += int'(fc32_en);
    endtask

    task automatic clr();
        c_cpu = 0; c_f1 = 0; c_f8 = 0; c_f32 = 0; c_fc = 0; c_fc32 = 0;
    endtask

    task automatic run(input int n, input bit mt, input bit st);
        for (int i = 0; i < n; i++) step(mt, st);
    endtask

    task automatic wr(input logic [7:0] d);
        step(0, 0, 1, d);
    endtask

    task automatic rd(input string tag, input logic [7:0] exp);
        step(0, 0);
        push(tag, int'(reg_rdata), int'(exp));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) step(0, 0);
        rst_n = 1'b1;
        // R1: reset value, sub-clock off
        rd("R1 reset value", 8'h4A);
        clr(); run(16, 0, 1);
        push("R1 fc off after reset", c_fc, 0);
        // R2/R6: divide by 8 and peripheral ratios from reset
        clr(); run(64, 1, 0);
        push("R2 cpu div8", c_cpu, 8);
        push("R6 f1", c_f1, 64);
        push("R6 f8", c_f8, 8);
        push("R6 f32", c_f32, 2);
        // R3: old period of 8 completes before div1 applies
        div_hi = 2'b00; wr(8'h0A);
        clr(); run(8, 1, 0);
        push("R3 old div8 period", c_cpu, 1);
        clr(); run(10, 1, 0);
        push("R2 cpu div1", c_cpu, 10);
        div_hi = 2'b11;
        clr(); run(1, 1, 0);
        clr(); run(32, 1, 0);
        push("R2 cpu div16", c_cpu, 2);
        clr(); run(4, 1, 0);
        div_hi = 2'b01;
        clr(); run(12, 1, 0);
        push("R3 mid-period change keeps 16", c_cpu, 1);
        clr(); run(8, 1, 0);
        push("R2 cpu div2", c_cpu, 4);
        div_hi = 2'b10;
        clr(); run(2, 1, 0);
        clr(); run(16, 1, 0);
        push("R2 cpu div4", c_cpu, 4);
        // R10: bit 0 ignores writes
        wr(8'h4B);
        rd("R10 bit0 reads 0", 8'h4A);
        // R5: main stop refused while main is the source
        wr(8'h6A);
        rd("R5 main stop refused", 8'h4A);
        // R4: select needs enabled and stable sub-oscillator
        sub_stable = 1'b1; wr(8'hDA);
        rd("R4 select refused, sub off", 8'h5A);
        sub_stable = 1'b0; wr(8'hDA);
        rd("R4 select refused, unstable", 8'h5A);
        sub_stable = 1'b1; wr(8'hDA);
        rd("R4 select accepted", 8'hDA);
        clr(); run(64, 1, 1);
        push("R4 cpu follows sub", c_cpu, 64);
        push("R8 fc", c_fc, 64);
        push("R8 fc32", c_fc32, 2);
        // R5/R6: main stop accepted on sub source, peripherals silent
        wr(8'hFA);
        rd("R5 main stop accepted", 8'hFA);
        clr(); run(16, 1, 0);
        push("R6 f1 off with main stopped", c_f1, 0);
        push("R6 cpu silent, sub idle", c_cpu, 0);
        wr(8'h6A);
        rd("R5 select held while stopped", 8'hFA);
        // R9: stop entry from low-speed keeps bits 6 and 1
        wr(8'hDA); wr(8'h90);
        rd("R9 setup slow", 8'h90);
        step(0, 0, 0, 8'h00, 0, 0, 1);
        rd("R9 stop from slow", 8'h98);
        wr(8'h10);
        rd("R9 setup fast", 8'h10);
        step(0, 0, 0, 8'h00, 0, 0, 1);
        rd("R9 stop from fast", 8'h5A);
        // R7: WAIT gating and release timing
        wr(8'h5E);
        clr(); run(8, 1, 0);
        push("R7 f1 before wait", c_f1, 8);
        clr(); step(1, 0, 0, 8'h00, 1);
        push("R7 wait cycle still ticks", c_f1, 1);
        clr(); run(10, 1, 0);
        push("R7 f1 gated in wait", c_f1, 0);
        clr(); step(1, 0, 0, 8'h00, 0, 1);
        push("R7 gated on irq cycle", c_f1, 0);
        clr(); run(5, 1, 0);
        push("R7 f1 resumes", c_f1, 5);
        wr(8'h5A);
        clr(); step(1, 0, 0, 8'h00, 1); run(6, 1, 0);
        push("R7 wait ignored with bit2 clear", c_f1, 7);
        step(0, 0, 0, 8'h00, 0, 1);
        repeat (3) step(0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule